// File: doc/BRIEF.md
# Unaligned Little-Endian Load/Store Unit

This block connects an execution core to a memory that is organised in 32-bit words. The core sends it one load or store at a time. Each request names a byte, halfword or word at any byte address in a 24-bit space. The unit turns the request into one aligned word transaction, or into two when the bytes run across a word boundary. For stores it places the data on the correct byte lanes and raises the matching byte enables. For loads it collects the bytes from one or both words, puts them into little-endian order and extends them to 32 bits.

A parameter sets the top of populated memory. The unit checks every request against this limit before it starts any memory traffic. If any byte of the request lies at or above the limit, the unit returns a fault and leaves memory untouched. The core side uses a valid/ready request and a single-cycle response pulse. The memory side uses a valid/ready word handshake. Read data is taken from the memory in the same cycle as the handshake.

Top module: `ldst_align_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_valid` is 0.
- R2: A request whose bytes all lie in one word causes exactly one memory transaction, at word index `req_addr[23:2]`.
- R3: A request whose bytes run into the next word causes exactly two transactions: first the word at `req_addr[23:2]`, then the word one index higher.
- R4: A store writes only the bytes it covers. In `mem_be`, bit i enables byte lane i, which is byte address offset i within the word. Every other byte of memory keeps its value.
- R5: Stores are little-endian: byte k of `req_wdata` (bits 8k+7..8k) is written to byte address `req_addr`+k.
- R6: Loads are little-endian: byte k of the loaded value comes from byte address `req_addr`+k. The size code is 0 for byte, 1 for halfword and 2 for word. A store response carries zero data.
- R7: For byte and halfword loads, `req_signed`=1 copies the top bit of the loaded value into the upper bits of the result. `req_signed`=0 fills them with zeros.
- R8: If any byte of a request lies at or above `MEM_TOP`, the response has `rsp_fault`=1 and zero data. No memory transaction is issued for that request.
- R9: Size code 3 is reserved. A request with it gets a fault response and causes no memory transaction.
- R10: Only one request is in flight at a time. `req_ready` is 0 from acceptance until the response. `rsp_valid` is a one-cycle pulse, and `req_ready` returns to 1 in the next cycle.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, the memory request fields (`mem_addr`, `mem_be`, `mem_write`, `mem_wdata`) stay unchanged and `mem_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Unit is idle and accepts a request |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store value, right-aligned |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_fault | output | 1 | Request referenced a missing address or used the reserved size |
| rsp_rdata | output | 32 | Extended load value; zero for stores and faults |
| mem_valid | output | 1 | Word transaction requested |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_write | output | 1 | Transaction is a write |
| mem_addr | output | ADDR_W-2 | Word index |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Read word, valid during the handshake |

## Verification
Errors in the lane mask or the word-increment path show up as wrong transaction counts and word indices on the memory port. They are visible within the same request. Wrong byte placement leaves a corrupted byte in the memory image, which the bench detects after each store and again when the words are read back. Merge or extension errors show up in the response value of the affected load. A wrong sequencer state shows up as a missing or doubled response strobe, or as `req_ready` staying low, within one or two cycles of the last handshake. Every address in the small configuration, including those just above the memory top, is tried with every size and signedness. These sweeps reach all four offsets and every split case.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } ldst_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_RESP = 2'd3
  } ldst_state_e;
endpackage

// File: rtl/ldst_plan.sv
// Decodes an address and size into byte lanes over two words, the two word
// indices, a split flag and the range/size fault.
module ldst_plan
  import ldst_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int MEM_TOP = 1 << 20
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          size,
  output logic [2*WORD_BYTES-1:0] lanes,
  output logic                split,
  output logic                fault,
  output logic [ADDR_W-3:0]   word_lo,
  output logic [ADDR_W-3:0]   word_hi
);
  localparam int WA = ADDR_W - 2;
  localparam logic [ADDR_W:0] TOP_X = (ADDR_W+1)'(MEM_TOP);

  logic [WORD_BYTES-1:0] base;
  logic [WA:0]           wlo_x;
  logic [WA:0]           whi_x;
  logic                  lo_out;
  logic                  hi_out;

  always_comb begin
    case (ldst_size_e'(size))
      SZ_BYTE: base = 4'b0001;
      SZ_HALF: base = 4'b0011;
      SZ_WORD: base = 4'b1111;
      default: base = 4'b0000;
    endcase
    lanes = {{WORD_BYTES{1'b0}}, base} << addr[OFF_W-1:0];
  end

  assign split   = |lanes[2*WORD_BYTES-1:WORD_BYTES];
  assign wlo_x   = {1'b0, addr[ADDR_W-1:OFF_W]};
  assign whi_x   = wlo_x + (WA+1)'(1);
  assign lo_out  = {wlo_x, 2'b00} >= TOP_X;
  assign hi_out  = {whi_x, 2'b00} >= TOP_X;
  assign fault   = (ldst_size_e'(size) == SZ_RSVD) | lo_out | (split & hi_out);
  assign word_lo = wlo_x[WA-1:0];
  assign word_hi = whi_x[WA-1:0];
endmodule

// File: rtl/ldst_store_lane.sv
// Places a right-aligned store value onto the byte lanes of a two-word window.
module ldst_store_lane
  import ldst_pkg::*;
(
  input  logic [DATA_W-1:0]   wdata,
  input  logic [OFF_W-1:0]    off,
  output logic [2*DATA_W-1:0] wide
);
  assign wide = {{DATA_W{1'b0}}, wdata} << {off, 3'b000};
endmodule

// File: rtl/ldst_load_merge.sv
// Gathers little-endian bytes from the two captured words and extends them.
module ldst_load_merge
  import ldst_pkg::*;
(
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [DATA_W-1:0] value
);
  logic [2*DATA_W-1:0] wide;
  logic [7:0]          pick [WORD_BYTES];

  assign wide = {hi_word, lo_word};

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_pick
    logic [OFF_W:0] idx;
    assign idx     = {1'b0, off} + (OFF_W+1)'(k);
    assign pick[k] = wide[{idx, 3'b000} +: 8];
  end

  always_comb begin
    case (ldst_size_e'(size))
      SZ_BYTE: value = {{24{sgn & pick[0][7]}}, pick[0]};
      SZ_HALF: value = {{16{sgn & pick[1][7]}}, pick[1], pick[0]};
      default: value = {pick[3], pick[2], pick[1], pick[0]};
    endcase
  end
endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int MEM_TOP = 1 << 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [31:0]       rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam logic [ADDR_W:0] TOP_X = (ADDR_W+1)'(MEM_TOP);

  ldst_state_e state_q, state_d;

  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              sgn_q;
  logic              wr_q;
  logic [31:0]       wdata_q;
  logic [31:0]       lo_q;
  logic [31:0]       hi_q;

  logic [7:0]          lanes;
  logic                split;
  logic                fault;
  logic [ADDR_W-3:0]   word_lo;
  logic [ADDR_W-3:0]   word_hi;
  logic [63:0]         wide_st;
  logic [31:0]         merged;

  logic accept;
  logic lo_take;
  logic hi_take;
  logic in_hi;

  ldst_plan #(.ADDR_W(ADDR_W), .MEM_TOP(MEM_TOP)) u_plan (
    .addr    (addr_q),
    .size    (size_q),
    .lanes   (lanes),
    .split   (split),
    .fault   (fault),
    .word_lo (word_lo),
    .word_hi (word_hi)
  );

  ldst_store_lane u_store (
    .wdata (wdata_q),
    .off   (addr_q[OFF_W-1:0]),
    .wide  (wide_st)
  );

  ldst_load_merge u_merge (
    .lo_word (lo_q),
    .hi_word (hi_q),
    .off     (addr_q[OFF_W-1:0]),
    .size    (size_q),
    .sgn     (sgn_q),
    .value   (merged)
  );

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign in_hi   = (state_q == ST_HI);
  assign lo_take = (state_q == ST_LO) && !fault && mem_ready;
  assign hi_take = in_hi && mem_ready;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_LO;
      ST_LO: begin
        if (fault)          state_d = ST_RESP;
        else if (mem_ready) state_d = split ? ST_HI : ST_RESP;
      end
      ST_HI:   if (mem_ready) state_d = ST_RESP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= req_addr;
      size_q  <= req_size;
      sgn_q   <= req_signed;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  // read word capture, enabled per handshake
  always_ff @(posedge clk) begin
    if (lo_take) lo_q <= mem_rdata;
    if (hi_take) hi_q <= mem_rdata;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_valid = ((state_q == ST_LO) && !fault) || in_hi;
  assign mem_write = wr_q;
  assign mem_addr  = in_hi ? word_hi : word_lo;
  assign mem_be    = in_hi ? lanes[7:4] : lanes[3:0];
  assign mem_wdata = in_hi ? wide_st[63:32] : wide_st[31:0];
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_fault = rsp_valid && fault;
  assign rsp_rdata = (rsp_valid && !fault && !wr_q) ? merged : 32'h0;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_write) && $stable(mem_wdata)); // R11

  AST_MEM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ({1'b0, mem_addr, 2'b00} < TOP_X)); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R10

  AST_BUSY_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HI) && ($past(state_q) != ST_HI) |-> $past((state_q == ST_LO) && mem_ready)); // R3

  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be != 4'b0000)); // R4
endmodule

// File: tb/sim_ldst_align_unit.sv
module sim_ldst_align_unit;
  localparam int AW  = 24;
  localparam int TOP = 64;
  localparam int NW  = TOP / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_signed;
  logic [1:0]  req_size;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_ready, mem_write;
  logic [AW-3:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  ldst_align_unit #(.ADDR_W(AW), .MEM_TOP(TOP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_signed(req_signed),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] seed_byte(int i);
    return 8'(i * 37 + 11);
  endfunction

  // behavioural memory with pseudo-random ready
  logic [7:0] bmem [0:TOP-1];
  logic [7:0] lfsr;
  int hs_total;
  int hs_prev, hs_last;
  int oob;

  assign mem_ready = lfsr[0] | lfsr[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr     <= 8'hA5;
      hs_total <= 0;
      hs_prev  <= -1;
      hs_last  <= -1;
      oob      <= 0;
      for (int i = 0; i < TOP; i++) bmem[i] <= seed_byte(i);
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_valid && mem_ready) begin
        hs_total <= hs_total + 1;
        hs_prev  <= hs_last;
        hs_last  <= int'(mem_addr);
        if (int'(mem_addr) >= NW) oob <= oob + 1;
        else if (mem_write)
          for (int j = 0; j < 4; j++)
            if (mem_be[j]) bmem[int'(mem_addr) * 4 + j] <= mem_wdata[8*j +: 8];
      end
    end
  end

  always_comb begin
    mem_rdata = 32'hDEAD_BEEF;
    if (int'(mem_addr) < NW)
      for (int j = 0; j < 4; j++) mem_rdata[8*j +: 8] = bmem[int'(mem_addr) * 4 + j];
  end

  logic [7:0] ref_mem [0:TOP-1];

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input bit sg, input logic [AW-1:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output bit flt, output int ntx);
    int start;
    @(negedge clk);
    start      = hs_total;
    req_valid  = 1'b1;
    req_write  = wr;
    req_size   = sz;
    req_signed = sg;
    req_addr   = a;
    req_wdata  = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd  = rsp_rdata;
    flt = rsp_fault;
    ntx = hs_total - start;
    check(req_ready == 1'b0, "R10 busy during response", 32'(req_ready), 32'h0);
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R10 ready after response pulse",
          {30'b0, req_ready, rsp_valid}, 32'h2);
  endtask

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit exp_fault(logic [1:0] sz, int a);
    return (sz == 2'd3) || (a + nbytes(sz) - 1 >= TOP);
  endfunction

  initial begin
    logic [31:0] rd, expv;
    bit flt, ef;
    int ntx, etx, n;

    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_signed = 1'b0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < TOP; i++) ref_mem[i] = seed_byte(i);
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_valid, "R1 state in reset",
          {29'b0, req_ready, rsp_valid, mem_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_valid, "R1 state after reset",
          {29'b0, req_ready, rsp_valid, mem_valid}, 32'h4);

    // load sweep over every address near and beyond the top
    for (int a = 0; a < TOP + 8; a++)
      for (int s = 0; s < 4; s++)
        for (int g = 0; g < 2; g++) begin
          access(1'b0, 2'(s), g[0], AW'(a), 32'h0, rd, flt, ntx);
          n  = nbytes(2'(s));
          ef = exp_fault(2'(s), a);
          expv = 32'h0;
          if (!ef) begin
            for (int k = 0; k < n; k++) expv[8*k +: 8] = ref_mem[a + k];
            if (g == 1 && n < 4 && expv[8*n-1]) expv = expv | (32'hFFFF_FFFF << (8*n));
          end
          check(flt == ef, (s == 3) ? "R9 reserved size fault" : "R8 load fault flag",
                32'(flt), 32'(ef));
          check(rd == expv, (g == 1) ? "R6 R7 signed load value" : "R6 R7 unsigned load value",
                rd, expv);
          etx = ef ? 0 : (((a % 4) + n > 4) ? 2 : 1);
          check(ntx == etx, (etx == 2) ? "R3 two transactions" :
                            (etx == 1) ? "R2 one transaction" : "R8 no transaction on fault",
                32'(ntx), 32'(etx));
          if (etx == 2)
            check(hs_prev == a / 4 && hs_last == a / 4 + 1, "R3 lower word first",
                  32'(hs_prev), 32'(a / 4));
          else if (etx == 1)
            check(hs_last == a / 4, "R2 word index", 32'(hs_last), 32'(a / 4));
        end

    // far address: must fault without memory traffic
    access(1'b0, 2'd2, 1'b0, 24'hFFFFFE, 32'h0, rd, flt, ntx);
    check(flt && ntx == 0 && rd == 0, "R8 top of address space", {rd[29:0], 1'b0, flt}, 32'h1);

    // store sweep with memory image comparison after each store
    for (int a = 0; a < TOP + 8; a++)
      for (int s = 0; s < 4; s++) begin
        logic [31:0] wd;
        bit same;
        wd = 32'h9E37_79B9 ^ (32'(a) * 32'h0101_0101) ^ 32'(s * 77);
        access(1'b1, 2'(s), 1'b0, AW'(a), wd, rd, flt, ntx);
        n  = nbytes(2'(s));
        ef = exp_fault(2'(s), a);
        if (!ef) for (int k = 0; k < n; k++) ref_mem[a + k] = wd[8*k +: 8];
        check(flt == ef, (s == 3) ? "R9 reserved store fault" : "R8 store fault flag",
              32'(flt), 32'(ef));
        check(rd == 32'h0, "R6 store response data", rd, 32'h0);
        etx = ef ? 0 : (((a % 4) + n > 4) ? 2 : 1);
        check(ntx == etx, "R2 R3 store transaction count", 32'(ntx), 32'(etx));
        same = 1'b1;
        for (int i = 0; i < TOP; i++) if (bmem[i] !== ref_mem[i]) same = 1'b0;
        check(same, "R4 R5 memory image after store", 32'(a), 32'(s));
      end

    // read back every word through the unit
    for (int w = 0; w < NW; w++) begin
      access(1'b0, 2'd2, 1'b0, AW'(w * 4), 32'h0, rd, flt, ntx);
      expv = {ref_mem[w*4+3], ref_mem[w*4+2], ref_mem[w*4+1], ref_mem[w*4]};
      check(!flt && rd == expv, "R5 R6 word readback", rd, expv);
    end

    check(oob == 0, "R8 no transaction beyond top", 32'(oob), 32'h0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog R10 run did not complete actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule